// File: doc/BRIEF.md
# Cascadable Serial Frame Receiver

This block receives 16-bit command frames from a host over a four-wire synchronous serial link in clock mode 0. An active-low select encloses each frame. While the select is asserted, each rising edge of the serial clock shifts one data bit into an internal shift register, most significant bit first. When the select is released after at least a full frame, the block places the last 16 received bits on a parallel bus. A strobe, high for one system-clock cycle, marks the new word. Decoding that word is left to the logic that consumes it.

The block also drives a serial data output, so that several receivers can share one select and one clock in a chain. Each bit leaves the shift register through a spill stage and then a stage updated on the falling edge. A bit therefore reaches the output sixteen and a half serial clocks after it entered, and the next device in the chain can sample it on the seventeenth rising edge. The output enable is low whenever the select is high. The link pins are brought into the system clock domain through a configurable synchronizer, and edges of the serial clock are detected there. The serial clock must therefore be slow compared with the system clock.

Top module: `spi_dc_top`

## Requirements
- R1: After reset, `word_vld`, `word_out`, `sdo` and `sdo_en` are all 0.
- R2: When the select rises after exactly 16 rising serial-clock edges, `word_out` holds those bits. The first bit received sits in bit 15 and the last in bit 0.
- R3: Each committed frame raises `word_vld` for exactly one system-clock cycle. `word_out` changes only in a cycle where `word_vld` is high.
- R4: Serial-clock edges and data seen while the select is high leave the shift register unchanged. This shows at the output when the next frame begins.
- R5: `sdo` changes only after a detected falling edge of the serial clock. It stays constant across the rising edge.
- R6: A bit received on rising edge k is present on `sdo` when rising edge k+17 arrives, within one select window.
- R7: The shift register keeps its contents across frames. During rising edges 2 to 17 of a frame, `sdo` presents the previous 16 received bits, oldest (MSB) first.
- R8: `sdo_en` is 0 while the select is high and 1 while it is low, measured after the input synchronizer latency.
- R9: If more than 16 rising edges arrive in one window, the committed word is the last 16 bits received.
- R10: If fewer than 16 rising edges arrive before the select rises, no strobe is issued and `word_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out toward the next chained device |
| sdo_en | output | 1 | Output-driver enable for `sdo` (1 = drive, 0 = high impedance) |
| word_out | output | FRAME_W | Last committed frame |
| word_vld | output | 1 | One-cycle strobe for a new `word_out` |

## Verification
The checker looks at every cycle. It confirms that the strobe never lasts two cycles and that the parallel word moves only with the strobe. It confirms that the strobe follows a select release and that the serial output moves only after a falling edge. It also confirms that the shift register is frozen while the select is inactive. Other behaviours need the bench's frames. These are the exact bit order of the committed word, the sixteen-and-a-half-clock delay, the carry-over of earlier bits into the next frame, and the discard of short frames and trimming of long ones. The bench compares each bit on the serial output with its own model of the received history.

// File: rtl/spi_dc_pkg.sv
package spi_dc_pkg;
   typedef struct packed {
      logic sclk;
      logic cs_n;
      logic sdi;
   } spi_pins_t;

   localparam spi_pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, sdi: 1'b0};

   function automatic int cnt_bits(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/spi_dc_sync.sv
module spi_dc_sync #(
   parameter int              STAGES  = 2,
   parameter int              W       = 3,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
            end else begin
               chain[0] <= d;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_dc_edge.sv
module spi_dc_edge
   import spi_dc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  spi_pins_t pins,
   output logic      sclk_rise,
   output logic      sclk_fall,
   output logic      cs_rise,
   output logic      cs_act
);
   logic sclk_prev;
   logic cs_n_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         cs_n_prev <= 1'b1;
      end else begin
         sclk_prev <= pins.sclk;
         cs_n_prev <= pins.cs_n;
      end
   end

   assign sclk_rise = pins.sclk & ~sclk_prev;
   assign sclk_fall = ~pins.sclk & sclk_prev;
   assign cs_rise   = pins.cs_n & ~cs_n_prev;
   assign cs_act    = ~pins.cs_n;
endmodule

// File: rtl/spi_dc_shift.sv
module spi_dc_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_act,
   input  logic         sclk_rise,
   input  logic         sclk_fall,
   input  logic         sdi_s,
   output logic [W-1:0] shreg_q,
   output logic         full,
   output logic         sdo
);
   localparam int CW = spi_dc_pkg::cnt_bits(W);
   localparam logic [CW-1:0] CNT_MAX = CW'(W);

   logic [CW-1:0] cnt;
   logic          spill;
   logic          shift_en;
   logic          out_en;

   assign shift_en = sclk_rise & cs_act;
   assign out_en   = sclk_fall & cs_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         shreg_q <= '0;
         spill   <= 1'b0;
         sdo     <= 1'b0;
      end else begin
         if (!cs_act)
            cnt <= '0;
         else if (shift_en && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
         if (shift_en) begin
            spill   <= shreg_q[W-1];
            shreg_q <= {shreg_q[W-2:0], sdi_s};
         end
         if (out_en)
            sdo <= spill;
      end
   end

   assign full = (cnt == CNT_MAX);
endmodule

// File: rtl/spi_dc_commit.sv
module spi_dc_commit #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_rise,
   input  logic         full,
   input  logic [W-1:0] shreg_q,
   output logic [W-1:0] word_out,
   output logic         word_vld
);
   logic take;
   assign take = cs_rise & full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_out <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= take;
         if (take) word_out <= shreg_q;
      end
   end
endmodule

// File: rtl/spi_dc_top.sv
module spi_dc_top
   import spi_dc_pkg::*;
#(
   parameter int FRAME_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               sdi,
   output logic               sdo,
   output logic               sdo_en,
   output logic [FRAME_W-1:0] word_out,
   output logic               word_vld
);
   generate
      if (FRAME_W < 2) begin : g_bad_width
         $error("spi_dc_top: FRAME_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("spi_dc_top: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   spi_pins_t            pins_raw;
   spi_pins_t            pins_s;
   logic                 sclk_rise;
   logic                 sclk_fall;
   logic                 cs_rise;
   logic                 cs_act;
   logic                 full;
   logic [FRAME_W-1:0]   shreg_q;

   assign pins_raw = '{sclk: sclk, cs_n: cs_n, sdi: sdi};

   spi_dc_sync #(
      .STAGES  (SYNC_STAGES),
      .W       ($bits(spi_pins_t)),
      .RST_VAL (PINS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   spi_dc_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins      (pins_s),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .cs_rise   (cs_rise),
      .cs_act    (cs_act)
   );

   spi_dc_shift #(.W(FRAME_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .sdi_s     (pins_s.sdi),
      .shreg_q   (shreg_q),
      .full      (full),
      .sdo       (sdo)
   );

   spi_dc_commit #(.W(FRAME_W)) u_commit (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_rise  (cs_rise),
      .full     (full),
      .shreg_q  (shreg_q),
      .word_out (word_out),
      .word_vld (word_vld)
   );

   assign sdo_en = cs_act;
endmodule

// File: rtl/spi_dc_chk.sv
module spi_dc_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         sdo,
   input logic         word_vld,
   input logic [W-1:0] word_out,
   input logic         sclk_fall,
   input logic         cs_rise,
   input logic         cs_act,
   input logic [W-1:0] shreg_q
);
   // R3
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld);

   // R3
   word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(word_out) |-> word_vld);

   // R2
   vld_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> $past(cs_rise));

   // R5
   sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo) |-> $past(sclk_fall));

   // R4
   shreg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> $stable(shreg_q));
endmodule

bind spi_dc_top spi_dc_chk #(.W(FRAME_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sdo       (sdo),
   .word_vld  (word_vld),
   .word_out  (word_out),
   .sclk_fall (sclk_fall),
   .cs_rise   (cs_rise),
   .cs_act    (cs_act),
   .shreg_q   (shreg_q)
);

// File: tb/sim_spi_dc_top.sv
module sim_spi_dc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b1;
   logic        sdi = 1'b0;
   logic        sdo;
   logic        sdo_en;
   logic [15:0] word_out;
   logic        word_vld;

   int checks = 0;
   int fails = 0;
   int vld_seen = 0;
   int vld_runs = 0;
   logic vld_prev = 1'b0;
   logic done = 1'b0;
   logic [15:0] hist = '0;

   always #4 clk = ~clk;

   spi_dc_top #(.FRAME_W(16), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
      .sdo(sdo), .sdo_en(sdo_en), .word_out(word_out), .word_vld(word_vld)
   );

   always @(negedge clk) begin
      if (word_vld) vld_seen++;
      if (word_vld && vld_prev) vld_runs++;
      vld_prev <= word_vld;
   end

   // {bits[5:0], data[31:0], strobe[0], word[15:0]}
   localparam logic [54:0] VEC [0:8] = '{
      {6'd16, 32'h0000_A5C3, 1'b1, 16'hA5C3},
      {6'd16, 32'h0000_FFFF, 1'b1, 16'hFFFF},
      {6'd16, 32'h0000_0000, 1'b1, 16'h0000},
      {6'd20, 32'h000F_1234, 1'b1, 16'h1234},
      {6'd8,  32'h0000_0055, 1'b0, 16'h1234},
      {6'd32, 32'hDEAD_BEEF, 1'b1, 16'hBEEF},
      {6'd17, 32'h0001_8001, 1'b1, 16'h8001},
      {6'd3,  32'h0000_0005, 1'b0, 16'h8001},
      {6'd16, 32'h0000_3C96, 1'b1, 16'h3C96}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input int n, input logic [31:0] data, input string old_tag);
      logic [15:0] h0;
      logic        pre;
      h0 = hist;
      chk("R8", "sdo_en idle", {31'd0, sdo_en}, 32'd0);
      cs_n = 1'b0;
      wait_clk(4);
      chk("R8", "sdo_en active", {31'd0, sdo_en}, 32'd1);
      for (int m = 1; m <= n; m++) begin
         sdi = data[n-m];
         wait_clk(4);
         if (m >= 2) begin
            if (m - 1 <= 16)
               chk(old_tag, "carried bit", {31'd0, sdo}, {31'd0, h0[16-(m-1)]});
            else
               chk("R6", "delayed bit", {31'd0, sdo}, {31'd0, data[n-(m-17)]});
         end
         pre = sdo;
         sclk = 1'b1;
         hist = {hist[14:0], data[n-m]};
         wait_clk(2);
         chk("R5", "sdo across rise", {31'd0, sdo}, {31'd0, pre});
         wait_clk(2);
         sclk = 1'b0;
      end
      wait_clk(4);
      cs_n = 1'b1;
      wait_clk(8);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      int v0;
      wait_clk(3);
      chk("R1", "vld in reset", {31'd0, word_vld}, 32'd0);
      rst_n = 1'b1;
      wait_clk(3);
      chk("R1", "word after reset", {16'd0, word_out}, 32'd0);
      chk("R1", "sdo after reset", {31'd0, sdo}, 32'd0);
      chk("R1", "sdo_en after reset", {31'd0, sdo_en}, 32'd0);

      for (int i = 0; i < 9; i++) begin
         v0 = vld_seen;
         send(int'(VEC[i][54:49]), VEC[i][48:17], "R7");
         if (VEC[i][16]) begin
            chk(VEC[i][54:49] > 16 ? "R9" : "R2", "word", {16'd0, word_out}, {16'd0, VEC[i][15:0]});
            chk("R3", "strobe count", v0 + 1, vld_seen);
         end else begin
            chk("R10", "word kept", {16'd0, word_out}, {16'd0, VEC[i][15:0]});
            chk("R10", "no strobe", v0, vld_seen);
         end
      end
      chk("R3", "strobe width", vld_runs, 0);

      // clocks with the select high must not disturb the shift register
      send(16, 32'h0000_6A5B, "R7");
      v0 = vld_seen;
      for (int k = 0; k < 6; k++) begin
         sdi = k[0];
         wait_clk(4);
         sclk = 1'b1;
         wait_clk(4);
         sclk = 1'b0;
      end
      wait_clk(6);
      chk("R4", "no strobe while idle", v0, vld_seen);
      chk("R8", "sdo_en while idle", {31'd0, sdo_en}, 32'd0);
      send(16, 32'h0000_0F0F, "R4");
      chk("R2", "word after idle clocks", {16'd0, word_out}, 32'h0F0F);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule